// File: doc/BRIEF.md
# Low-Speed Tap Divider with Edge Interrupts

This block divides a slow reference tick (nominally 32.768 kHz, delivered as a one-cycle enable pulse in the system clock domain) with a 15-bit binary counter. Eight counter bits, the square waves from 128 Hz down to 1 Hz, are gathered into one readable byte. Software reads that byte to tell time at coarse resolution. It restarts the divider by writing to the same address; the value written does not matter.

Three interrupt channels each watch one of the eight taps, chosen by a 3-bit select field, and latch a request flag when the chosen tap goes from 1 to 0. Each channel has an enable bit that gates its flag onto an interrupt line. A flag is still captured while its enable is off. Software clears a flag by writing 0 to its bit. A divider restart that pulls a selected tap from 1 to 0 counts as a falling edge, so software that restarts the divider must expect a request from it.

Top module: `lowspeed_tap_timer`

## Requirements
- R1: After reset the counter is zero, every flag and enable bit is 0, and the select fields are 7 (channel 0), 4 (channel 1) and 1 (channel 2).
- R2: The counter advances by one on each clock where `lsclk_en` is high and holds otherwise. A read of address 0 returns the taps with bit 7 = counter bit 7 (128 Hz) down to bit 0 = counter bit 14 (1 Hz).
- R3: Any write to address 0 sets the counter to zero whatever the write data, so address 0 then reads 0.
- R4: Addresses 1, 2 and 3 hold the select fields of channels 0, 1 and 2 in bits [2:0]. Bits [7:3] read as 0. Value s picks tap byte bit s.
- R5: A channel's flag is set on the clock edge after the one at which its selected tap falls from 1 to 0. It is not yet set in the cycle where the tap has just fallen.
- R6: A write to address 0 while a channel's selected tap is 1 sets that channel's flag one cycle later.
- R7: Address 4 bits [2:0] are the enables. `irq[i]` is high exactly when flag i and enable i are both 1. Flags are captured while enables are 0.
- R8: Address 5 bits [2:0] are the flags. Writing 0 to a bit clears that flag and writing 1 leaves it unchanged. A falling edge in the same cycle as a clear wins, and the flag ends up set.
- R9: Changing a select field does not by itself set a flag, even when the old tap is 1 and the new tap is 0.
- R10: Rising edges of the selected tap, and any edge of an unselected tap, leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsclk_en | input | 1 | One-cycle pulse marking each low-speed clock tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| irq | output | 3 | Per-channel interrupt line, flag AND enable |

## Verification
The divider is run three ways. First, with a tick on every clock for more than two full counter periods, so that every tap, including the 1 Hz tap, falls at least twice. Second, with sparse, irregular ticks mixed with random select rewrites, which separates "advance per tick" from "advance per clock" and shows that a select change alone raises nothing. Third, with the tick held off while registers are written, which isolates the request caused by a restart from requests caused by counting. Directed cases place a flag clear in the same cycle as a falling edge, and compare the cycle just after a tap falls with the one after it, to pin the one-cycle request delay.

// File: rtl/lstt_pkg.sv
// Shared constants for the low-speed tap timer: counter and tap geometry,
// channel count, bus widths and the register address map.
package lstt_pkg;
    localparam int CNT_W  = 15;               // divider length
    localparam int TAP_N  = 8;                // taps visible in the tap byte
    localparam int SEL_W  = $clog2(TAP_N);    // width of a tap-select field
    localparam int CH_N   = 3;                // interrupt channels
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_TAPS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(1 + CH_N);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2 + CH_N);
endpackage

// File: rtl/lstt_divider.sv
// Binary divider for the low-speed tick.
// Counts lsclk enable pulses. A clear request overrides counting.
// Exposes the top TAP_N counter bits as taps (bit TAP_N-1 = fastest) and a
// one-cycle falling-edge vector per tap, derived from a registered copy.
// Assumes: tick is already synchronous to clk; CNT_W >= TAP_N.
module lstt_divider #(
    parameter int CNT_W = lstt_pkg::CNT_W,
    parameter int TAP_N = lstt_pkg::TAP_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [TAP_N-1:0] taps,
    output logic [TAP_N-1:0] fall
);
    logic [CNT_W-1:0] cnt;
    logic [TAP_N-1:0] taps_q;

    // Counter: clear on request, else step once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end

    // Tap byte: bit b follows counter bit CNT_W-1-b.
    for (genvar b = 0; b < TAP_N; b++) begin : g_tap
        assign taps[b] = cnt[CNT_W-1-b];
    end

    // Previous tap values, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            taps_q <= '0;
        else
            taps_q <= taps;
    end

    // A tap that was 1 and is now 0 has fallen (counting or clear alike).
    assign fall = taps_q & ~taps;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && taps == '0));
endmodule

// File: rtl/lstt_channel.sv
// One interrupt channel: tap-select field, enable bit and request flag.
// The flag latches the falling edge of the selected tap on the next clock.
// Software may clear it by writing 0; a same-cycle edge wins over a clear.
// Assumes: fall is a per-tap one-cycle edge vector from the divider, so a
// select change never fabricates an edge.
module lstt_channel #(
    parameter int               TAP_N    = lstt_pkg::TAP_N,
    parameter int               SEL_W    = lstt_pkg::SEL_W,
    parameter logic [SEL_W-1:0] SEL_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_N-1:0] fall,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             ena_wr,
    input  logic             ena_wdata,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic [SEL_W-1:0] sel,
    output logic             ena,
    output logic             flag,
    output logic             irq
);
    logic fall_sel;

    // Edge on the currently selected tap.
    assign fall_sel = fall[sel];

    // Select field register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= SEL_INIT;
        else if (sel_wr)
            sel <= sel_wdata;
    end

    // Enable bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ena <= 1'b0;
        else if (ena_wr)
            ena <= ena_wdata;
    end

    // Request flag: set by edge, cleared by writing 0, edge has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (fall_sel)
            flag <= 1'b1;
        else if (flag_wr && !flag_wdata)
            flag <= 1'b0;
    end

    // Interrupt line gated by enable.
    assign irq = flag & ena;

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_sel |=> flag);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata && !fall_sel) |=> !flag);

    // R10
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(fall_sel));
endmodule

// File: rtl/lstt_bus.sv
// Register access decode for the tap timer.
// Turns a write strobe and address into per-register write enables and
// multiplexes the read data. Read data is combinational; unused bits are 0.
// Assumes: at most one register address is active per cycle.
module lstt_bus #(
    parameter int TAP_N  = lstt_pkg::TAP_N,
    parameter int SEL_W  = lstt_pkg::SEL_W,
    parameter int CH_N   = lstt_pkg::CH_N,
    parameter int ADDR_W = lstt_pkg::ADDR_W,
    parameter int DATA_W = lstt_pkg::DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [TAP_N-1:0]      taps,
    input  logic [CH_N*SEL_W-1:0] sel_all,
    input  logic [CH_N-1:0]       ena_all,
    input  logic [CH_N-1:0]       flag_all,
    output logic                  cnt_clr,
    output logic [CH_N-1:0]       sel_wr,
    output logic                  ena_wr,
    output logic                  flag_wr,
    output logic [DATA_W-1:0]     rdata
);
    import lstt_pkg::*;

    // Write enables for the divider and the shared enable/flag registers.
    assign cnt_clr = wr && (addr == A_TAPS);
    assign ena_wr  = wr && (addr == A_ENA);
    assign flag_wr = wr && (addr == A_FLAG);

    // Per-channel select write enables.
    for (genvar i = 0; i < CH_N; i++) begin : g_selwr
        assign sel_wr[i] = wr && (addr == ADDR_W'(int'(A_SEL0) + i));
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (addr == A_TAPS)
            rdata[TAP_N-1:0] = taps;
        else if (addr == A_ENA)
            rdata[CH_N-1:0] = ena_all;
        else if (addr == A_FLAG)
            rdata[CH_N-1:0] = flag_all;
        for (int i = 0; i < CH_N; i++) begin
            if (addr == ADDR_W'(int'(A_SEL0) + i))
                rdata[SEL_W-1:0] = sel_all[i*SEL_W +: SEL_W];
        end
    end

    // R4
    sel_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_wr, ena_wr, flag_wr, cnt_clr}));
endmodule

// File: rtl/lowspeed_tap_timer.sv
// Low-speed tap timer top: divider, register decode and CH_N edge channels.
// Each channel watches the tap picked by its select field and requests an
// interrupt on that tap's falling edge; a divider clear counts as an edge.
// Assumes: single clock domain; the low-speed clock arrives as lsclk_en.
module lowspeed_tap_timer #(
    parameter int CNT_W  = lstt_pkg::CNT_W,
    parameter int TAP_N  = lstt_pkg::TAP_N,
    parameter int CH_N   = lstt_pkg::CH_N,
    parameter int ADDR_W = lstt_pkg::ADDR_W,
    parameter int DATA_W = lstt_pkg::DATA_W,
    parameter int SEL_W  = $clog2(TAP_N),
    parameter logic [CH_N*SEL_W-1:0] SEL_INIT = {3'd1, 3'd4, 3'd7}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsclk_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CH_N-1:0]   irq
);
    logic [TAP_N-1:0]      taps;
    logic [TAP_N-1:0]      fall;
    logic                  cnt_clr;
    logic [CH_N-1:0]       sel_wr;
    logic                  ena_wr;
    logic                  flag_wr;
    logic [CH_N*SEL_W-1:0] sel_all;
    logic [CH_N-1:0]       ena_all;
    logic [CH_N-1:0]       flag_all;

    lstt_divider #(.CNT_W(CNT_W), .TAP_N(TAP_N)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (lsclk_en),
        .clr  (cnt_clr),
        .taps (taps),
        .fall (fall)
    );

    lstt_bus #(
        .TAP_N(TAP_N), .SEL_W(SEL_W), .CH_N(CH_N),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .taps    (taps),
        .sel_all (sel_all),
        .ena_all (ena_all),
        .flag_all(flag_all),
        .cnt_clr (cnt_clr),
        .sel_wr  (sel_wr),
        .ena_wr  (ena_wr),
        .flag_wr (flag_wr),
        .rdata   (bus_rdata)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        lstt_channel #(
            .TAP_N(TAP_N), .SEL_W(SEL_W),
            .SEL_INIT(SEL_INIT[i*SEL_W +: SEL_W])
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .fall      (fall),
            .sel_wr    (sel_wr[i]),
            .sel_wdata (bus_wdata[SEL_W-1:0]),
            .ena_wr    (ena_wr),
            .ena_wdata (bus_wdata[i]),
            .flag_wr   (flag_wr),
            .flag_wdata(bus_wdata[i]),
            .sel       (sel_all[i*SEL_W +: SEL_W]),
            .ena       (ena_all[i]),
            .flag      (flag_all[i]),
            .irq       (irq[i])
        );
    end

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_wr && bus_wdata[CH_N-1:0] == '0) |=> irq == '0);
endmodule

// File: tb/lowspeed_tap_timer_bench.sv
`timescale 1ns/1ps
module lowspeed_tap_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       lsclk_en;
    logic       bus_wr;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [2:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Behavioural reference state.
    int         m_cnt;
    logic [7:0] m_prev;
    int         m_sel[3];
    logic [2:0] m_en;
    logic [2:0] m_flag;

    always #2.5 clk = ~clk;

    lowspeed_tap_timer u_lowspeed_tap_timer (
        .clk(clk), .rst_n(rst_n), .lsclk_en(lsclk_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    function automatic logic [7:0] tap_of(int c);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = 1'((c >> (14 - b)) & 1);
        return r;
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return tap_of(m_cnt);
            3'd1, 3'd2, 3'd3: return 8'(m_sel[a - 1]);
            3'd4: return {5'd0, m_en};
            3'd5: return {5'd0, m_flag};
            default: return 8'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1, 3'd2, 3'd3: return "R4";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: drive, advance the model, sample after the edge, compare.
    task automatic step(logic en, logic wr, logic [2:0] a, logic [7:0] d);
        logic [7:0] t_now, f;
        logic [2:0] nf;
        lsclk_en = en; bus_wr = wr; bus_addr = a; bus_wdata = d;
        t_now = tap_of(m_cnt);
        f = m_prev & ~t_now;
        for (int i = 0; i < 3; i++) begin
            nf[i] = m_flag[i];
            if (wr && a == 3'd5 && !d[i]) nf[i] = 1'b0;
            if (f[m_sel[i]]) nf[i] = 1'b1;
        end
        m_flag = nf;
        m_prev = t_now;
        if (wr && a == 3'd0) m_cnt = 0;
        else if (en) m_cnt = (m_cnt + 1) % 32768;
        if (wr && a >= 3'd1 && a <= 3'd3) m_sel[a - 1] = int'(d[2:0]);
        if (wr && a == 3'd4) m_en = d[2:0];
        @(posedge clk);
        @(negedge clk);
        lsclk_en = 1'b0; bus_wr = 1'b0;
        check(tag_of(a), int'(bus_rdata), int'(m_read(a)), "read data");
        check("R7", int'(irq), int'(m_flag & m_en), "irq lines");
    endtask

    task automatic peek(logic [2:0] a, string req, int exp);
        bus_addr = a;
        #1;
        check(req, int'(bus_rdata), exp, "register read");
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lsclk_en = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'd0;
        m_cnt = 0; m_prev = '0; m_en = '0; m_flag = '0;
        m_sel[0] = 7; m_sel[1] = 4; m_sel[2] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(3'd0, "R1", 0);
        peek(3'd1, "R1", 7);
        peek(3'd2, "R1", 4);
        peek(3'd3, "R1", 1);
        peek(3'd4, "R1", 0);
        peek(3'd5, "R1", 0);
        check("R1", int'(irq), 0, "irq after reset");

        // R4: upper bits of a select write are dropped
        step(1'b0, 1'b1, 3'd3, 8'hFD);
        peek(3'd3, "R4", 5);
        step(1'b0, 1'b1, 3'd3, 8'h01);

        // Dense ticks: every tap falls at least twice (R2, R5, R10)
        step(1'b0, 1'b1, 3'd4, 8'h07);
        for (int k = 0; k < 70000; k++) begin
            if (k % 997 == 996) step(1'b1, 1'b1, 3'd5, 8'h00);
            else step(1'b1, 1'b0, 3'(k % 6), 8'h00);
        end

        // Sparse ticks with select rewrites and occasional restarts (R2, R3, R9)
        for (int k = 0; k < 30000; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 3) step(1'b0, 1'b1, 3'(1 + $urandom % 3), 8'($urandom));
            else if (r == 3 && k % 7 == 0) step(1'b0, 1'b1, 3'd0, 8'($urandom));
            else if (r == 4) step(1'b0, 1'b1, 3'd5, 8'($urandom));
            else step(1'($urandom % 3 == 0), 1'b0, 3'($urandom % 6), 8'h00);
        end

        // Restore default selects
        step(1'b0, 1'b1, 3'd1, 8'd7);
        step(1'b0, 1'b1, 3'd2, 8'd4);
        step(1'b0, 1'b1, 3'd3, 8'd1);

        // Bring the counter to 128 (tap bit 7 = 1, bit 6 = 0)
        step(1'b0, 1'b1, 3'd0, 8'h00);
        for (int k = 0; k < 128; k++) step(1'b1, 1'b0, 3'd5, 8'h00);
        peek(3'd0, "R2", 8'h80);
        // R10: bit 7 rose, no request on channel 0
        step(1'b0, 1'b1, 3'd5, 8'h00);
        step(1'b0, 1'b0, 3'd5, 8'h00);
        check("R10", int'(bus_rdata[0]), 0, "flag after rising tap");

        // R9: switch channel 1 from a high tap to a low tap
        step(1'b0, 1'b1, 3'd2, 8'd7);
        step(1'b0, 1'b1, 3'd2, 8'd6);
        step(1'b0, 1'b0, 3'd5, 8'h00);
        step(1'b0, 1'b0, 3'd5, 8'h00);
        check("R9", int'(bus_rdata[1]), 0, "flag after select change");
        step(1'b0, 1'b1, 3'd2, 8'd4);

        // R3 / R6: restart while channel 0 tap is high
        step(1'b0, 1'b1, 3'd0, 8'h5A);
        check("R3", int'(bus_rdata), 0, "taps after restart write");
        peek(3'd5, "R6", 0);
        step(1'b0, 1'b0, 3'd5, 8'h00);
        check("R6", int'(bus_rdata[0]), 1, "flag after restart");

        // R7: flag held while disabled, irq follows enable
        step(1'b0, 1'b1, 3'd4, 8'h00);
        check("R7", int'(irq[0]), 0, "irq disabled");
        step(1'b0, 1'b1, 3'd4, 8'h01);
        check("R7", int'(irq[0]), 1, "irq enabled");

        // R5: the flag appears one cycle after the tap has fallen
        for (int k = 0; k < 300 && tap_of(m_cnt)[7] == 1'b0; k++) step(1'b1, 1'b0, 3'd5, 8'h00);
        step(1'b0, 1'b1, 3'd5, 8'h00);
        for (int k = 0; k < 300 && !(m_prev[7] && !tap_of(m_cnt)[7]); k++)
            step(1'b1, 1'b0, 3'd5, 8'h00);
        check("R5", int'(bus_rdata[0]), 0, "flag in cycle of tap fall");
        step(1'b0, 1'b0, 3'd5, 8'h00);
        check("R5", int'(bus_rdata[0]), 1, "flag one cycle later");

        // R8: plain clear, then clear colliding with an edge
        step(1'b0, 1'b1, 3'd5, 8'h06);
        check("R8", int'(bus_rdata[0]), 0, "flag after write 0");
        for (int k = 0; k < 300 && tap_of(m_cnt)[7] == 1'b0; k++) step(1'b1, 1'b0, 3'd5, 8'h00);
        for (int k = 0; k < 300 && !(m_prev[7] && !tap_of(m_cnt)[7]); k++)
            step(1'b1, 1'b0, 3'd5, 8'h00);
        step(1'b0, 1'b1, 3'd5, 8'h00);
        check("R8", int'(bus_rdata[0]), 1, "edge beats clear");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule